// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog that counts down in sixteenth-of-a-second steps, driven by an external single-cycle `tick` strobe at 16 Hz. Software programs one configuration byte that holds a 5-bit multiplier, a 2-bit resolution and a steering bit. The timeout is the multiplier times a power of four, so short and long intervals fit in the same byte. Software must service the watchdog before the count runs out. Both writing and reading the configuration byte service it.

On expiry the block sets a sticky flag in a read-only status byte. The steering bit then picks one action. One choice is a one-cycle reset request, which also wipes the configuration and clears one bit in a general control byte. The other choice is a one-cycle interrupt pulse, which leaves the configuration in place. Each programmed countdown produces at most one event.

The register bus is a simple synchronous strobe interface. Read data is registered and is valid in the cycle after the read strobe.

Top module: `wdog_tick_timer`

## Requirements
- R1: The configuration byte sits at offset 0. Its fields are: bit 7 is the steering bit, bits 6:2 are the multiplier M, and bits 1:0 are the resolution S. After a restart, the countdown expires on exactly the (M × 4^S)-th tick. Expiry takes effect at the clock edge that samples that tick.
- R2: A bus write to offset 0 stores the byte and restarts the countdown with the new value. It also clears the expiry flag. A read of offset 0 returns the stored byte one cycle after the strobe.
- R3: A bus read of offset 0 restarts the countdown from the stored contents and clears the expiry flag.
- R4: Expiry sets bit 7 of the status byte at offset 1. The other status bits always read 0.
- R5: If the steering bit is 1 at expiry, `reset_req` is high for exactly one cycle, in the cycle after the expiring tick edge. The configuration byte becomes 0x00, and bit 6 of the control byte at offset 2 is cleared while its other bits keep their values.
- R6: If the steering bit is 0 at expiry, `irq` is high for exactly one cycle instead, and the configuration byte is kept.
- R7: The status byte is read-only. Bus writes to offset 1 leave the expiry flag unchanged.
- R8: Synchronous reset clears the configuration, the flag, the control byte and the read data, and it stops any countdown in progress. After reset, no event occurs until the watchdog is reprogrammed.
- R9: A multiplier of 0 leaves the watchdog disarmed, so no number of ticks produces an event.
- R10: After an expiry, further ticks produce no event until the next restart. `reset_req` and `irq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tick | input | 1 | One-cycle strobe at 16 Hz |
| reset_req | output | 1 | One-cycle reset request on steered expiry |
| irq | output | 1 | One-cycle interrupt on unsteered expiry |

## Verification
A count that is loaded or decremented wrongly shows up as a pulse one tick early or late. The bench therefore holds one tick short of each table timeout and checks for silence, then checks that the next tick produces a pulse. A stale armed state shows up as a second pulse on later ticks, or as a pulse after a zero multiplier or after reset. Faults in the flag or in the steered clearing logic show up in the status, control and configuration reads taken right after an expiry. A restart that fails shows up as a pulse fewer than the programmed number of ticks after a service access.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W     = MULT_W + MAX_SHIFT;
    localparam int FLAG_BIT  = DATA_W - 1;
    localparam int CTRL_BIT  = 6;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG   = 2'd0,
        REG_STAT  = 2'd1,
        REG_CTRL  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    function automatic logic [CNT_W-1:0] timeout_ticks(input wd_cfg_t c);
        logic [CNT_W-1:0] base;
        base = CNT_W'(c.mult);
        return base << (2 * c.res);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire_i,
    output logic              restart_o,
    output logic [CNT_W-1:0]  load_ticks_o,
    output logic              steer_o,
    output logic [DATA_W-1:0] bus_rdata
);

    wd_cfg_t           cfg_q;
    logic              flag_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    wd_cfg_t           next_cfg;
    reg_addr_e         dec;
    logic              wr_cfg, wr_ctrl, wr_stat, steered_exp;

    assign dec         = reg_addr_e'(bus_addr);
    assign restart_o   = bus_sel && (dec == REG_CFG);
    assign wr_cfg      = restart_o && bus_we;
    assign wr_ctrl     = bus_sel && bus_we && (dec == REG_CTRL);
    assign wr_stat     = bus_sel && bus_we && (dec == REG_STAT);
    assign steered_exp = expire_i && cfg_q.steer;

    // a write loads the incoming value, a read reloads the stored one
    assign next_cfg     = bus_we ? wd_cfg_t'(bus_wdata) : cfg_q;
    assign load_ticks_o = timeout_ticks(next_cfg);
    assign steer_o      = cfg_q.steer;

    always_comb begin
        rd_mux = '0;
        case (dec)
            REG_CFG:  rd_mux = cfg_q;
            REG_STAT: rd_mux[FLAG_BIT] = flag_q;
            REG_CTRL: rd_mux = ctrl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            flag_q  <= 1'b0;
            ctrl_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (restart_o)
                flag_q <= 1'b0;
            else if (expire_i)
                flag_q <= 1'b1;

            if (wr_cfg)
                cfg_q <= wd_cfg_t'(bus_wdata);
            else if (steered_exp)
                cfg_q <= '0;

            if (wr_ctrl)
                ctrl_q <= bus_wdata;
            else if (steered_exp)
                ctrl_q[CTRL_BIT] <= 1'b0;

            if (bus_sel && !bus_we)
                rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    // R2 / R3: any service access leaves the flag clear
    a_r2_service_clears_flag: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !flag_q);

    // R7: status writes never move the flag
    a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !expire_i) |=> (flag_q == $past(flag_q)));

    // R4: expiry raises the flag
    a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> flag_q);

    // R5: steered expiry wipes configuration and control bit
    a_r5_steer_clears: assert property (@(posedge clk) disable iff (rst)
        (steered_exp && !(bus_sel && bus_we)) |=> (cfg_q == '0 && !ctrl_q[CTRL_BIT]));

    // R6: unsteered expiry keeps configuration
    a_r6_irq_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
        (expire_i && !cfg_q.steer && !(bus_sel && bus_we)) |=> $stable(cfg_q));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_ticks_i,
    input  logic             steer_i,
    output logic             expire_o,
    output logic             reset_req_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             rst_pulse_q;
    logic             irq_pulse_q;
    logic             last_tick;

    assign last_tick = (cnt_q == CNT_W'(1));
    // a service access in the same cycle wins over the expiring tick
    assign expire_o  = tick_i && armed_q && last_tick && !restart_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            armed_q     <= 1'b0;
            rst_pulse_q <= 1'b0;
            irq_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= expire_o && steer_i;
            irq_pulse_q <= expire_o && !steer_i;
            if (restart_i) begin
                cnt_q   <= load_ticks_i;
                armed_q <= (load_ticks_i != '0);
            end else if (tick_i && armed_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (last_tick)
                    armed_q <= 1'b0;
            end
        end
    end

    assign reset_req_o = rst_pulse_q;
    assign irq_o       = irq_pulse_q;

    // R10: outputs are exclusive single-cycle pulses
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rst_pulse_q && irq_pulse_q));
    a_r5_one_cycle_reset: assert property (@(posedge clk) disable iff (rst)
        rst_pulse_q |=> !rst_pulse_q);
    a_r6_one_cycle_irq: assert property (@(posedge clk) disable iff (rst)
        irq_pulse_q |=> !irq_pulse_q);

    // R10: expiry disarms until the next restart
    a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !armed_q);

    // R9: a zero timeout never arms
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (restart_i && load_ticks_i == '0) |=> !armed_q);

    // R1: the count moves only on ticks
    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick,
    output logic              reset_req,
    output logic              irq
);

    logic             restart;
    logic             expire;
    logic             steer;
    logic [CNT_W-1:0] load_ticks;

    wdt_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (reg_sel),
        .bus_we       (reg_we),
        .bus_addr     (reg_addr),
        .bus_wdata    (reg_wdata),
        .expire_i     (expire),
        .restart_o    (restart),
        .load_ticks_o (load_ticks),
        .steer_o      (steer),
        .bus_rdata    (reg_rdata)
    );

    wdt_countdown u_count (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .restart_i    (restart),
        .load_ticks_i (load_ticks),
        .steer_i      (steer),
        .expire_o     (expire),
        .reset_req_o  (reset_req),
        .irq_o        (irq)
    );

    // R8: no event in the cycle after a reset
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!reset_req && !irq));

endmodule

// File: tb/wdog_tick_timer_bench.sv
module wdog_tick_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       reset_req;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int n_rst  = 0;
    int n_irq  = 0;

    localparam logic [1:0] A_CFG = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;
    localparam int NV = 7;
    localparam logic [7:0] V_CFG [NV] = '{8'h04, 8'h0D, 8'h7E, 8'h8B, 8'h95, 8'h7C, 8'hFF};
    localparam int         V_N   [NV] = '{1, 12, 496, 128, 20, 31, 1984};

    wdog_tick_timer u_wdog_tick_timer (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick(tick), .reset_req(reset_req), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            n_rst += int'(reset_req);
            n_irq += int'(irq);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk); reg_sel = 1'b0; d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int b_rst, b_irq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        check("R8 reset_req", int'(reset_req), 0);
        check("R8 irq", int'(irq), 0);
        check("R8 rdata", int'(reg_rdata), 0);
        bus_read(A_CFG, rd);  check("R8 cfg", int'(rd), 0);
        bus_read(A_STAT, rd); check("R8 status", int'(rd), 0);
        bus_read(A_CTRL, rd); check("R8 ctrl", int'(rd), 0);

        // R1 R4 R5 R6: table of timeouts
        for (int i = 0; i < NV; i++) begin
            bus_write(A_CTRL, 8'hFF);
            b_rst = n_rst; b_irq = n_irq;
            bus_write(A_CFG, V_CFG[i]);
            ticks(V_N[i] - 1);
            check("R1 early rst", n_rst - b_rst, 0);
            check("R1 early irq", n_irq - b_irq, 0);
            ticks(1);
            check("R5 reset pulse", n_rst - b_rst, V_CFG[i][7] ? 1 : 0);
            check("R6 irq pulse", n_irq - b_irq, V_CFG[i][7] ? 0 : 1);
            bus_read(A_STAT, rd); check("R4 flag", int'(rd), 'h80);
            bus_read(A_CTRL, rd); check("R5 ctrl bit6", int'(rd), V_CFG[i][7] ? 'hBF : 'hFF);
            bus_read(A_CFG, rd);  check("R5 R6 cfg after", int'(rd), V_CFG[i][7] ? 0 : int'(V_CFG[i]));
        end

        // R10: one event per countdown
        b_irq = n_irq; b_rst = n_rst;
        bus_write(A_CFG, 8'h04);
        ticks(1);
        ticks(6);
        check("R10 single irq", n_irq - b_irq, 1);
        check("R10 no reset", n_rst - b_rst, 0);

        // R7: status is read-only
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, rd); check("R7 write 0 kept flag", int'(rd), 'h80);
        bus_read(A_CFG, rd);  check("R2 readback", int'(rd), 'h04);
        bus_read(A_STAT, rd); check("R3 read clears flag", int'(rd), 0);
        bus_write(A_STAT, 8'hFF);
        bus_read(A_STAT, rd); check("R7 write FF ignored", int'(rd), 0);

        // R3: a read restarts the countdown
        bus_write(A_CFG, 8'h0C);
        b_irq = n_irq;
        ticks(2);
        bus_read(A_CFG, rd); check("R2 readback 0C", int'(rd), 'h0C);
        ticks(2);
        check("R3 no early irq", n_irq - b_irq, 0);
        ticks(1);
        check("R3 irq after restart", n_irq - b_irq, 1);

        // R2: a write restarts and clears the flag
        bus_write(A_CFG, 8'h0C);
        bus_read(A_STAT, rd); check("R2 write clears flag", int'(rd), 0);
        b_irq = n_irq;
        ticks(2);
        bus_write(A_CFG, 8'h10);
        ticks(3);
        check("R2 no early irq", n_irq - b_irq, 0);
        ticks(1);
        check("R2 irq new value", n_irq - b_irq, 1);

        // R9: zero multiplier
        b_irq = n_irq; b_rst = n_rst;
        bus_write(A_CFG, 8'h83);
        ticks(100);
        check("R9 no reset", n_rst - b_rst, 0);
        check("R9 no irq", n_irq - b_irq, 0);
        bus_read(A_STAT, rd); check("R9 flag clear", int'(rd), 0);

        // R8: reset mid-countdown
        bus_write(A_CFG, 8'h0C);
        ticks(2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        b_irq = n_irq; b_rst = n_rst;
        ticks(5);
        check("R8 stopped irq", n_irq - b_irq, 0);
        check("R8 stopped rst", n_rst - b_rst, 0);
        bus_read(A_CFG, rd); check("R8 cfg cleared", int'(rd), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule